// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block keeps a free-running cycle count and raises an interrupt when the count reaches a programmed value. A counter of parameterised width advances by one on every clock. A 32-bit compare register is checked against the low 32 bits of that count. When the two are equal, a sticky pending flag is set. The interrupt output is that flag gated by an enable input. An acknowledge pulse clears the flag.

Reads and writes use the same register access point but reach different storage. A read strobe captures the whole counter. A write strobe loads the compare register, which cannot be read back. Software reads the count, adds its interval, and writes the sum. If the value it writes is already behind the count, the interrupt waits until the low 32 bits wrap round to it. Each instance stands alone and shares nothing with other instances.

Top module: `tick_alarm`

## Requirements
- R1: After reset the counter is zero. It then grows by exactly one on every clock and wraps at its full width, CNT_W (32 or 64 bits).
- R2: A read strobe (`rd_en` high at an edge) loads `rd_data` with the counter value as it stood before that edge's increment. Without a read strobe, `rd_data` keeps its value.
- R3: A write strobe (`wr_en` high at an edge) loads the 32-bit `wr_data` into the compare register. That register is write-only, and reads return the counter.
- R4: At any edge where counter bits [31:0] equal the compare register, the pending flag is set. A compare value written at an edge is first used at the following edge.
- R5: `irq` is a register. After each edge it equals the pending flag after that edge ANDed with `irq_en` as sampled at that edge. With `irq_en` low, `irq` is low, but the pending flag is kept.
- R6: An `irq_ack` pulse clears the pending flag. If a match and an acknowledge fall on the same edge, the match wins and the flag stays set.
- R7: Writing a new compare value does not clear a flag that is already pending.
- R8: A compare value that the low counter bits have already passed raises nothing until those bits wrap round to it.
- R9: Reset clears the counter, the compare register, the pending flag, `irq` and `rd_data`. Because the counter and the compare register are both zero, the first edge after reset records a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe: load the compare register |
| wr_data | input | 32 | New compare value |
| rd_en | input | 1 | Read strobe: capture the counter |
| rd_data | output | CNT_W | Captured counter value |
| irq_en | input | 1 | Interrupt enable (mask) |
| irq_ack | input | 1 | Acknowledge pulse: clear pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims an acknowledge at the exact edge where a match occurs. A design that lets the acknowledge win there would lose an interrupt.

It writes a compare value that the counter has already passed, then watches for a wrong fire. A magnitude compare, rather than an equality compare, would fire at once.

It rewrites the compare register while a flag is pending, which catches a design that clears the flag on a write. It also checks the match that follows reset, and checks that the compare register takes a write one edge late. Random compare targets, enables, acknowledges and reads are checked cycle by cycle against a bench model, which also exposes off-by-one latency on `rd_data` and `irq`.

// File: rtl/tick_alarm_pkg.sv
package tick_alarm_pkg;
  localparam int CMP_W = 32;
endpackage

// File: rtl/tick_alarm_counter.sv
module tick_alarm_counter #(
  parameter int CNT_W = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [tick_alarm_pkg::CMP_W-1:0]  cnt_lo_o,
  output logic [CNT_W-1:0]                  rd_data_o
);
  import tick_alarm_pkg::*;
  localparam int HI_W = CNT_W - CMP_W;

  logic [CMP_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) lo_q <= '0;
    else     lo_q <= lo_q + 1'b1;
  end

  generate
    if (HI_W > 0) begin : g_split
      // upper half advances on the carry out of the lower half
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)          hi_q <= '0;
        else if (&lo_q)   hi_q <= hi_q + 1'b1;
      end
      assign cnt_o = {hi_q, lo_q};
    end else begin : g_narrow
      assign cnt_o = lo_q;
    end
  endgenerate

  assign cnt_lo_o = lo_q;

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= cnt_o;
  end
endmodule

// File: rtl/tick_alarm_compare.sv
module tick_alarm_compare (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [tick_alarm_pkg::CMP_W-1:0]  wr_data,
  input  logic [tick_alarm_pkg::CMP_W-1:0]  cnt_lo,
  output logic [tick_alarm_pkg::CMP_W-1:0]  cmp_o,
  output logic                              hit_o
);
  always_ff @(posedge clk) begin
    if (rst)        cmp_o <= '0;
    else if (wr_en) cmp_o <= wr_data;
  end

  // equality only: a passed value waits for the wrap
  assign hit_o = (cnt_lo == cmp_o);
endmodule

// File: rtl/tick_alarm_flag.sv
module tick_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic ack,
  input  logic en,
  output logic pend_o,
  output logic irq_o
);
  logic pend_d;

  always_comb begin
    if (hit)      pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
    else          pend_d = pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= pend_d & en;
    end
  end
endmodule

// File: rtl/tick_alarm.sv
module tick_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq
);
  import tick_alarm_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] cnt_lo;
  logic [CMP_W-1:0] cmp_q;
  logic             hit;
  logic             pend_q;

  tick_alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rd_en(rd_en),
    .cnt_o(cnt_q), .cnt_lo_o(cnt_lo), .rd_data_o(rd_data)
  );

  tick_alarm_compare u_cmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cmp_o(cmp_q), .hit_o(hit)
  );

  tick_alarm_flag u_flag (
    .clk(clk), .rst(rst), .hit(hit), .ack(irq_ack), .en(irq_en),
    .pend_o(pend_q), .irq_o(irq)
  );
endmodule

// File: rtl/tick_alarm_chk.sv
module tick_alarm_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             rd_en,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq_en,
  input logic             irq_ack,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [31:0]      cmp_q,
  input logic             pend_q
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);

  p_read_counter_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst)) |-> rd_data == $past(cnt_q));

  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rd_data));

  p_cmp_load_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> cmp_q == $past(wr_data));

  p_match_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_q[31:0] == cmp_q)) |-> pend_q);

  p_irq_mask_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == (pend_q && $past(irq_en)));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_ack) && $past(cnt_q[31:0] != cmp_q)) |-> !pend_q);

  p_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && pend_q && !irq_ack)) |-> pend_q);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(pend_q)) |-> $past(cnt_q[31:0] == cmp_q));

  p_reset_state_r9: assert property (@(posedge clk)
    $past(rst) |-> (cnt_q == '0 && cmp_q == '0 && !pend_q && !irq && rd_data == '0));
endmodule

bind tick_alarm tick_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq_en(irq_en), .irq_ack(irq_ack),
  .irq(irq), .cnt_q(cnt_q), .cmp_q(cmp_q), .pend_q(pend_q)
);

// File: tb/tick_alarm_test.sv
module tick_alarm_test;
  localparam int CNT_W = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic             rd_en = 1'b0;
  logic [CNT_W-1:0] rd_data;
  logic             irq_en = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [CNT_W-1:0] m_cnt, m_rd;
  logic [31:0]      m_cmp;
  logic             m_pend, m_irq;

  always #10 clk = ~clk;

  tick_alarm #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp,
                     input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic hit_now();
    return m_cnt[31:0] == m_cmp;
  endfunction

  // one clock; inputs driven at negedge, outputs checked at the next negedge
  task automatic step(input logic wr, input logic [31:0] wd, input logic rd,
                      input logic en, input logic ack);
    logic h;
    wr_en = wr; wr_data = wd; rd_en = rd; irq_en = en; irq_ack = ack;
    @(posedge clk);
    h = hit_now();
    if (h)        m_pend = 1'b1;
    else if (ack) m_pend = 1'b0;
    m_irq = m_pend & en;
    if (rd) m_rd = m_cnt;
    if (wr) m_cmp = wd;
    m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    chk({{(CNT_W-1){1'b0}}, irq}, {{(CNT_W-1){1'b0}}, m_irq}, "R5 irq vs model");
    chk(rd_data, m_rd, "R2 rd_data vs model");
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0, en, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] r0;
    logic [31:0]      tgt;
    logic             en_r;
    void'($urandom(32'd2024));
    m_cnt = '0; m_rd = '0; m_cmp = '0; m_pend = 1'b0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_data, '0, "R9 rd_data in reset");
    chk({{(CNT_W-1){1'b0}}, irq}, '0, "R9 irq in reset");
    rst = 1'b0;

    // R9: compare 0 meets counter 0 on the first edge out of reset
    step(1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk({{(CNT_W-1){1'b0}}, irq}, 1, "R9 first-edge match");
    chk(rd_data, '0, "R1 counter starts at zero");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
    chk({{(CNT_W-1){1'b0}}, irq}, 0, "R6 ack clears");

    // R1: counter step of one per clock
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    r0 = rd_data;
    idle(9, 1'b0);
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk(rd_data - r0, 10, "R1 ten clocks apart");

    // R4 + R5: masked match keeps pending, enabling shows it
    tgt = m_cnt[31:0] + 32'd5;
    step(1'b1, tgt, 1'b0, 1'b0, 1'b0);
    idle(8, 1'b0);
    chk({{(CNT_W-1){1'b0}}, irq}, 0, "R5 masked irq low");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    chk({{(CNT_W-1){1'b0}}, irq}, 1, "R4 match left pending");

    // R7: rewriting compare keeps pending
    step(1'b1, m_cnt[31:0] + 32'd1000, 1'b0, 1'b1, 1'b0);
    chk({{(CNT_W-1){1'b0}}, irq}, 1, "R7 write keeps pending");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
    chk({{(CNT_W-1){1'b0}}, irq}, 0, "R6 ack after write");

    // R6: match and ack on the same edge
    tgt = m_cnt[31:0] + 32'd4;
    step(1'b1, tgt, 1'b0, 1'b1, 1'b0);
    while (m_cnt[31:0] != tgt) step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
    chk({{(CNT_W-1){1'b0}}, irq}, 1, "R6 match wins over ack");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

    // R4: compare written at an edge equal to that edge's count is too late
    step(1'b1, m_cnt[31:0], 1'b0, 1'b1, 1'b0);
    chk({{(CNT_W-1){1'b0}}, irq}, 0, "R4 write lands one edge late");

    // R8: passed value does not fire
    step(1'b1, m_cnt[31:0] - 32'd5, 1'b0, 1'b1, 1'b0);
    idle(400, 1'b1);
    chk({{(CNT_W-1){1'b0}}, irq}, 0, "R8 passed value silent");

    // R3: compare is write-only; read returns counter
    step(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0);
    r0 = m_cnt;
    step(1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk(rd_data, r0, "R3 read gives counter not compare");

    // random phase
    en_r = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic        w, r, a;
      logic [31:0] d;
      w = ($urandom % 20) == 0;
      r = ($urandom % 4) == 0;
      a = ($urandom % 10) == 0;
      if (($urandom % 50) == 0) en_r = ~en_r;
      d = m_cnt[31:0] + 32'($urandom % 40) + 32'd1;
      step(w, d, r, en_r, a);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule